// File: doc/BRIEF.md
# Color Bar and Overlay Source Selector

This block produces the picture content for one video line, sample by sample, before it reaches sync insertion and analog conversion. A free-running sample counter follows the line length of the selected standard (525-line or 625-line timing, picked by `pal_sel`). A small state machine tracks which vertical bar of an eight-color test pattern the counter is in. The same machine also marks the leading blanking interval of each line.

Three sources compete for the output: the generated bar pattern, a flat overlay color built from three one-bit color inputs, and the incoming Y/Cb/Cr video. The bar enable wins over the overlay control, and the overlay control wins over video. A two-bit level input scales both generated sources to a quarter, half, three quarters or all of their full excursion. Incoming video is never scaled. During the blanking interval the output is forced to black whatever source is selected. Every output is registered once and carries a two-bit tag that names the source it came from.

The line state machine has nine states: `ST_HBLANK` and then one state per bar, `ST_WHITE`, `ST_YELLOW`, `ST_CYAN`, `ST_GREEN`, `ST_MAGENTA`, `ST_RED`, `ST_BLUE` and `ST_BLACK`. The machine moves from `ST_HBLANK` to `ST_WHITE` when the next count reaches the end of blanking. Each bar state moves to the following bar when the next count reaches that bar's right edge. From any state, the wrap of the counter at the end of the line returns it to `ST_HBLANK`. `ST_BLACK` is left only by that wrap.

Top module: `cbar_ovl_sel`

## Requirements
- R1: While `rst_n` is low, the outputs read Y=16, Cb=128, Cr=128 with tag 2'b11 (blank), and the sample count is 0. The first rising edge after release presents the result for sample 0.
- R2: The sample count runs 0 to 857 with `pal_sel`=0 and 0 to 863 with `pal_sel`=1, and then returns to 0. Sample 0 of the next line is again blanking.
- R3: With `pal_sel`=0, samples 0..126 are blanking and the bars start at 127, 216, 305, 394, 483, 572, 661 and 750. The black bar runs to sample 857.
- R4: With `pal_sel`=1, samples 0..141 are blanking and the bars start at 142, 230, 318, 406, 494, 582, 670 and 757. The black bar runs to sample 863.
- R5: From left to right the bars are white, yellow, cyan, green, magenta, red, blue and black. At full level their Y/Cb/Cr values are 235/128/128, 210/16/146, 170/166/16, 145/54/34, 106/202/222, 81/90/240, 41/240/110 and 16/128/128.
- R6: `level` values 0, 1, 2 and 3 give 25, 50, 75 and 100 percent. For generated colors the output is base + floor(excursion*(level+1)/4), where the base is 16 for Y and 128 for Cb and Cr, and the excursion is the full-level value minus that base. Generated luma stays within 16..235.
- R7: Outside blanking, when `bar_en`=1 the output is the bar color with tag 2'b10, whatever `ovl_en` and the overlay color bits are.
- R8: Outside blanking, when `bar_en`=0 and `ovl_en`=1, the output has tag 2'b01 and the color given by {`ovl_r`,`ovl_g`,`ovl_b`}. The codes map as follows: 111 white, 110 yellow, 011 cyan, 010 green, 101 magenta, 100 red, 001 blue, 000 black. Each color is scaled as in R6.
- R9: Outside blanking, when `bar_en`=0 and `ovl_en`=0, the output is `vid_y`/`vid_cb`/`vid_cr` unchanged, with no level scaling, and tag 2'b00.
- R10: During blanking, every source gives Y=16, Cb=128, Cr=128 with tag 2'b11.
- R11: The outputs change only at a rising edge. They reflect the inputs and the sample position present at that edge, one register stage after the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pal_sel | input | 1 | 0: 858-sample line timing, 1: 864-sample line timing |
| bar_en | input | 1 | Enables the bar pattern (highest priority) |
| ovl_en | input | 1 | Selects the overlay color when the bar pattern is off |
| ovl_r | input | 1 | Overlay red bit |
| ovl_g | input | 1 | Overlay green bit |
| ovl_b | input | 1 | Overlay blue bit |
| level | input | 2 | Generated color level: 0=25%, 1=50%, 2=75%, 3=100% |
| vid_y | input | 8 | Incoming luma |
| vid_cb | input | 8 | Incoming blue-difference chroma |
| vid_cr | input | 8 | Incoming red-difference chroma |
| out_y | output | 8 | Selected luma, registered |
| out_cb | output | 8 | Selected Cb, registered |
| out_cr | output | 8 | Selected Cr, registered |
| out_src | output | 2 | Source tag: 00 video, 01 overlay, 10 bar, 11 blank |

## Verification
The bar pattern is sampled on both sides of every bar edge in both standards. This separates an off-by-one boundary, a swapped edge table or a wrong line length from correct behaviour, because each of those moves a color by one sample or shifts the wrap. All eight overlay codes are swept at full and half level, which exposes any swapped color bit or wrong color entry. The lower levels are checked in the middle of every bar, where a truncating divide and a floor divide give different chroma. Priority is checked by holding the overlay control high under the bar pattern and then stepping the enables down. Video pass-through is checked with values that scaling would alter, and blanking is checked with every source active. A one-sample latency probe confirms the single register stage.

// File: rtl/cbos_pkg.sv
package cbos_pkg;

    localparam int NUM_BARS  = 8;
    localparam int NUM_EDGES = NUM_BARS - 1;

    localparam logic [7:0] LUMA_BASE   = 8'd16;
    localparam logic [7:0] CHROMA_BASE = 8'd128;

    typedef enum logic [3:0] {
        ST_HBLANK  = 4'd0,
        ST_WHITE   = 4'd1,
        ST_YELLOW  = 4'd2,
        ST_CYAN    = 4'd3,
        ST_GREEN   = 4'd4,
        ST_MAGENTA = 4'd5,
        ST_RED     = 4'd6,
        ST_BLUE    = 4'd7,
        ST_BLACK   = 4'd8
    } bar_state_e;

    typedef enum logic [1:0] {
        SRC_VIDEO   = 2'b00,
        SRC_OVERLAY = 2'b01,
        SRC_BAR     = 2'b10,
        SRC_BLANK   = 2'b11
    } src_tag_e;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] cb;
        logic [7:0] cr;
    } ycc_t;

    // Successor of a bar state in left-to-right order.
    function automatic bar_state_e next_bar(input bar_state_e s);
        bar_state_e n;
        unique case (s)
            ST_HBLANK:  n = ST_WHITE;
            ST_WHITE:   n = ST_YELLOW;
            ST_YELLOW:  n = ST_CYAN;
            ST_CYAN:    n = ST_GREEN;
            ST_GREEN:   n = ST_MAGENTA;
            ST_MAGENTA: n = ST_RED;
            ST_RED:     n = ST_BLUE;
            ST_BLUE:    n = ST_BLACK;
            default:    n = ST_BLACK;
        endcase
        return n;
    endfunction

    // Primary-color code {r,g,b} shown by a bar state.
    function automatic logic [2:0] state_rgb(input bar_state_e s);
        logic [2:0] c;
        unique case (s)
            ST_WHITE:   c = 3'b111;
            ST_YELLOW:  c = 3'b110;
            ST_CYAN:    c = 3'b011;
            ST_GREEN:   c = 3'b010;
            ST_MAGENTA: c = 3'b101;
            ST_RED:     c = 3'b100;
            ST_BLUE:    c = 3'b001;
            default:    c = 3'b000;
        endcase
        return c;
    endfunction

    // Full-level Y/Cb/Cr of a primary-color code.
    function automatic ycc_t full_color(input logic [2:0] rgb);
        ycc_t c;
        unique case (rgb)
            3'b111:  c = '{y: 8'd235, cb: 8'd128, cr: 8'd128};
            3'b110:  c = '{y: 8'd210, cb: 8'd16,  cr: 8'd146};
            3'b011:  c = '{y: 8'd170, cb: 8'd166, cr: 8'd16};
            3'b010:  c = '{y: 8'd145, cb: 8'd54,  cr: 8'd34};
            3'b101:  c = '{y: 8'd106, cb: 8'd202, cr: 8'd222};
            3'b100:  c = '{y: 8'd81,  cb: 8'd90,  cr: 8'd240};
            3'b001:  c = '{y: 8'd41,  cb: 8'd240, cr: 8'd110};
            default: c = '{y: 8'd16,  cb: 8'd128, cr: 8'd128};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cbos_linefsm.sv
module cbos_linefsm
    import cbos_pkg::*;
#(
    parameter int unsigned CW        = 10,
    parameter int unsigned NTSC_LINE = 858,
    parameter int unsigned PAL_LINE  = 864,
    parameter int unsigned NTSC_HB   = 127,
    parameter int unsigned PAL_HB    = 142,
    parameter logic [NUM_EDGES*CW-1:0] NTSC_EDGES = {10'd750, 10'd661, 10'd572, 10'd483,
                                                      10'd394, 10'd305, 10'd216},
    parameter logic [NUM_EDGES*CW-1:0] PAL_EDGES  = {10'd757, 10'd670, 10'd582, 10'd494,
                                                      10'd406, 10'd318, 10'd230}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pal_sel,
    output bar_state_e state_q,
    output logic       active
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic [CW-1:0] line_last;
    logic [CW-1:0] hb_end;
    logic [CW-1:0] cur_edge;
    logic [CW-1:0] edge_tbl [NUM_EDGES];
    logic          wrap;
    logic          advance;
    bar_state_e    state_nxt;

    // Right edge of each bar, picked per standard.
    for (genvar gi = 0; gi < NUM_EDGES; gi++) begin : g_edge
        assign edge_tbl[gi] = pal_sel ? PAL_EDGES[gi*CW +: CW] : NTSC_EDGES[gi*CW +: CW];
    end

    always_comb begin
        line_last = pal_sel ? CW'(PAL_LINE - 1) : CW'(NTSC_LINE - 1);
        hb_end    = pal_sel ? CW'(PAL_HB) : CW'(NTSC_HB);
        wrap      = (cnt_q >= line_last);
        cnt_nxt   = wrap ? '0 : cnt_q + CW'(1);
    end

    // Position at which the current state hands over to its successor.
    always_comb begin
        unique case (state_q)
            ST_HBLANK:  cur_edge = hb_end;
            ST_WHITE:   cur_edge = edge_tbl[0];
            ST_YELLOW:  cur_edge = edge_tbl[1];
            ST_CYAN:    cur_edge = edge_tbl[2];
            ST_GREEN:   cur_edge = edge_tbl[3];
            ST_MAGENTA: cur_edge = edge_tbl[4];
            ST_RED:     cur_edge = edge_tbl[5];
            ST_BLUE:    cur_edge = edge_tbl[6];
            default:    cur_edge = line_last;
        endcase
        advance = (cnt_nxt >= cur_edge) && (state_q != ST_BLACK);
    end

    always_comb begin
        if (wrap) begin
            state_nxt = ST_HBLANK;
        end else if (advance) begin
            state_nxt = next_bar(state_q);
        end else begin
            state_nxt = state_q;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            state_q <= ST_HBLANK;
        end else begin
            cnt_q   <= cnt_nxt;
            state_q <= state_nxt;
        end
    end

    // Outputs
    always_comb begin
        active = (state_q != ST_HBLANK);
    end

    AST_WRAP_TO_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == line_last) |=> (cnt_q == '0 && state_q == ST_HBLANK)); // R2

    AST_BLANK_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(pal_sel) && state_q == ST_HBLANK) |-> (cnt_q < hb_end)); // R3 R4

    AST_WHITE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(pal_sel) && state_q == ST_WHITE) |-> (cnt_q >= hb_end && cnt_q < edge_tbl[0])); // R3 R4

endmodule

// File: rtl/cbos_colorgen.sv
module cbos_colorgen
    import cbos_pkg::*;
(
    input  logic [2:0] rgb,
    input  logic [1:0] level,
    output ycc_t       color
);

    ycc_t       full;
    logic [2:0] mult;

    // base + floor((full - base) * mult / 4)
    function automatic logic [7:0] scale_comp(input logic [7:0] fullv,
                                              input logic [7:0] base,
                                              input logic [2:0] m);
        logic signed [9:0]  diff;
        logic signed [12:0] prod;
        logic signed [12:0] res;
        diff = $signed({2'b00, fullv}) - $signed({2'b00, base});
        prod = 13'(diff) * $signed({10'b0, m});
        res  = (prod >>> 2) + $signed({5'b0, base});
        return res[7:0];
    endfunction

    always_comb begin
        full     = full_color(rgb);
        mult     = {1'b0, level} + 3'd1;
        color.y  = scale_comp(full.y,  LUMA_BASE,   mult);
        color.cb = scale_comp(full.cb, CHROMA_BASE, mult);
        color.cr = scale_comp(full.cr, CHROMA_BASE, mult);
    end

endmodule

// File: rtl/cbos_srcsel.sv
module cbos_srcsel
    import cbos_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     active,
    input  logic     bar_en,
    input  logic     ovl_en,
    input  ycc_t     bar_col,
    input  ycc_t     ovl_col,
    input  ycc_t     vid_col,
    output ycc_t     out_q,
    output src_tag_e src_q
);

    localparam ycc_t BLACK = '{y: LUMA_BASE, cb: CHROMA_BASE, cr: CHROMA_BASE};

    src_tag_e sel;
    ycc_t     pick;

    // Priority: blanking, then bar, then overlay, then video.
    always_comb begin
        if (!active) begin
            sel = SRC_BLANK;
        end else if (bar_en) begin
            sel = SRC_BAR;
        end else if (ovl_en) begin
            sel = SRC_OVERLAY;
        end else begin
            sel = SRC_VIDEO;
        end
        unique case (sel)
            SRC_BAR:     pick = bar_col;
            SRC_OVERLAY: pick = ovl_col;
            SRC_VIDEO:   pick = vid_col;
            default:     pick = BLACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= BLACK;
            src_q <= SRC_BLANK;
        end else begin
            out_q <= pick;
            src_q <= sel;
        end
    end

    AST_BAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bar_en) |=> (src_q == SRC_BAR)); // R7

    AST_OVERLAY_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bar_en && ovl_en) |=> (src_q == SRC_OVERLAY)); // R8

    AST_VIDEO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bar_en && !ovl_en) |=> (src_q == SRC_VIDEO && out_q == $past(vid_col))); // R9

    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (src_q == SRC_BLANK && out_q.y == 8'd16 &&
                     out_q.cb == 8'd128 && out_q.cr == 8'd128)); // R10

    AST_LUMA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == SRC_BAR || src_q == SRC_OVERLAY) |-> (out_q.y >= 8'd16 && out_q.y <= 8'd235)); // R6

endmodule

// File: rtl/cbar_ovl_sel.sv
module cbar_ovl_sel
    import cbos_pkg::*;
#(
    parameter int unsigned CW        = 10,
    parameter int unsigned NTSC_LINE = 858,
    parameter int unsigned PAL_LINE  = 864,
    parameter int unsigned NTSC_HB   = 127,
    parameter int unsigned PAL_HB    = 142
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pal_sel,
    input  logic       bar_en,
    input  logic       ovl_en,
    input  logic       ovl_r,
    input  logic       ovl_g,
    input  logic       ovl_b,
    input  logic [1:0] level,
    input  logic [7:0] vid_y,
    input  logic [7:0] vid_cb,
    input  logic [7:0] vid_cr,
    output logic [7:0] out_y,
    output logic [7:0] out_cb,
    output logic [7:0] out_cr,
    output logic [1:0] out_src
);

    bar_state_e line_state;
    logic       line_active;
    ycc_t       bar_col;
    ycc_t       ovl_col;
    ycc_t       vid_col;
    ycc_t       sel_col;
    src_tag_e   sel_src;

    cbos_linefsm #(
        .CW        (CW),
        .NTSC_LINE (NTSC_LINE),
        .PAL_LINE  (PAL_LINE),
        .NTSC_HB   (NTSC_HB),
        .PAL_HB    (PAL_HB)
    ) u_linefsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pal_sel (pal_sel),
        .state_q (line_state),
        .active  (line_active)
    );

    cbos_colorgen u_bar_gen (
        .rgb   (state_rgb(line_state)),
        .level (level),
        .color (bar_col)
    );

    cbos_colorgen u_ovl_gen (
        .rgb   ({ovl_r, ovl_g, ovl_b}),
        .level (level),
        .color (ovl_col)
    );

    assign vid_col = '{y: vid_y, cb: vid_cb, cr: vid_cr};

    cbos_srcsel u_srcsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (line_active),
        .bar_en  (bar_en),
        .ovl_en  (ovl_en),
        .bar_col (bar_col),
        .ovl_col (ovl_col),
        .vid_col (vid_col),
        .out_q   (sel_col),
        .src_q   (sel_src)
    );

    assign out_y   = sel_col.y;
    assign out_cb  = sel_col.cb;
    assign out_cr  = sel_col.cr;
    assign out_src = sel_src;

endmodule

// File: tb/cbar_ovl_sel_bench.sv
`timescale 1ns/1ps
module cbar_ovl_sel_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pal_sel = 1'b0;
    logic       bar_en = 1'b0;
    logic       ovl_en = 1'b0;
    logic       ovl_r = 1'b0;
    logic       ovl_g = 1'b0;
    logic       ovl_b = 1'b0;
    logic [1:0] level = 2'd3;
    logic [7:0] vid_y = 8'd0;
    logic [7:0] vid_cb = 8'd0;
    logic [7:0] vid_cr = 8'd0;
    logic [7:0] out_y;
    logic [7:0] out_cb;
    logic [7:0] out_cr;
    logic [1:0] out_src;

    int checks = 0;
    int fails  = 0;
    int pos    = -1;
    int line   = 858;
    bit done   = 1'b0;

    localparam int NTSC_E [8] = '{127, 216, 305, 394, 483, 572, 661, 750};
    localparam int PAL_E  [8] = '{142, 230, 318, 406, 494, 582, 670, 757};
    localparam int BAR_CODE [8] = '{7, 6, 3, 2, 5, 4, 1, 0};

    always #2.5 clk = ~clk;

    cbar_ovl_sel u_cbar_ovl_sel (
        .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .bar_en(bar_en), .ovl_en(ovl_en),
        .ovl_r(ovl_r), .ovl_g(ovl_g), .ovl_b(ovl_b), .level(level),
        .vid_y(vid_y), .vid_cb(vid_cb), .vid_cr(vid_cr),
        .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr), .out_src(out_src)
    );

    function automatic int fdiv4(int v);
        if (v >= 0) return v / 4;
        return -((-v + 3) / 4);
    endfunction

    function automatic void ref_col(int code, int lvl, output int y, output int cb, output int cr);
        int by, bb, br;
        case (code)
            7: begin by = 235; bb = 128; br = 128; end
            6: begin by = 210; bb = 16;  br = 146; end
            3: begin by = 170; bb = 166; br = 16;  end
            2: begin by = 145; bb = 54;  br = 34;  end
            5: begin by = 106; bb = 202; br = 222; end
            4: begin by = 81;  bb = 90;  br = 240; end
            1: begin by = 41;  bb = 240; br = 110; end
            default: begin by = 16; bb = 128; br = 128; end
        endcase
        y  = 16  + fdiv4((by - 16)  * (lvl + 1));
        cb = 128 + fdiv4((bb - 128) * (lvl + 1));
        cr = 128 + fdiv4((br - 128) * (lvl + 1));
    endfunction

    function automatic int pos_code(int p, bit pal);
        int idx = 0;
        int first = pal ? PAL_E[0] : NTSC_E[0];
        if (p < first) return -1;
        for (int i = 1; i < 8; i++) begin
            if (p >= (pal ? PAL_E[i] : NTSC_E[i])) idx = i;
        end
        return BAR_CODE[idx];
    endfunction

    task automatic expect_out(string req, string what, int ey, int ecb, int ecr, int es);
        checks++;
        if (out_y !== 8'(ey) || out_cb !== 8'(ecb) || out_cr !== 8'(ecr) || out_src !== 2'(es)) begin
            fails++;
            $display("FAIL %s %s: actual y=%0d cb=%0d cr=%0d src=%0d expected y=%0d cb=%0d cr=%0d src=%0d",
                     req, what, out_y, out_cb, out_cr, out_src, ey, ecb, ecr, es);
        end
    endtask

    task automatic do_reset(bit pal);
        pal_sel = pal;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        pos  = -1;
        line = pal ? 864 : 858;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        pos = (pos + 1) % line;
    endtask

    task automatic go(int p);
        while (pos != p) step();
    endtask

    task automatic check_bar(string req, int p, int lvl);
        int code, y, cb, cr;
        go(p);
        code = pos_code(p, pal_sel);
        if (code < 0) begin
            expect_out(req, $sformatf("blank at %0d", p), 16, 128, 128, 3);
        end else begin
            ref_col(code, lvl, y, cb, cr);
            expect_out(req, $sformatf("bar at %0d", p), y, cb, cr, 2);
        end
    endtask

    // R1: reset state
    task automatic t_reset_state();
        bar_en = 1'b1; ovl_en = 1'b1; vid_y = 8'd99;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        expect_out("R1", "during reset", 16, 128, 128, 3);
        rst_n = 1'b1; pos = -1; line = 858;
        step();
        expect_out("R1", "first sample after release", 16, 128, 128, 3);
    endtask

    // R3 R5 R2 R7: NTSC bars at full level, overlay control also high
    task automatic t_bars_ntsc();
        bar_en = 1'b1; ovl_en = 1'b1; level = 2'd3;
        {ovl_r, ovl_g, ovl_b} = 3'b000;
        do_reset(1'b0);
        check_bar("R3", 0, 3);
        check_bar("R3", 126, 3);
        for (int i = 0; i < 8; i++) begin
            check_bar("R3 R5 R7", NTSC_E[i], 3);
            if (i < 7) check_bar("R3 R5", NTSC_E[i + 1] - 1, 3);
        end
        check_bar("R3 R5", 857, 3);
        check_bar("R2", 0, 3);
        check_bar("R2", 127, 3);
    endtask

    // R4 R5 R2: PAL bars
    task automatic t_bars_pal();
        bar_en = 1'b1; ovl_en = 1'b0; level = 2'd3;
        do_reset(1'b1);
        check_bar("R4", 141, 3);
        for (int i = 0; i < 8; i++) begin
            check_bar("R4 R5", PAL_E[i], 3);
            if (i < 7) check_bar("R4 R5", PAL_E[i + 1] - 1, 3);
        end
        check_bar("R4 R2", 858, 3);
        check_bar("R4 R2", 863, 3);
        check_bar("R2", 0, 3);
    endtask

    // R6: reduced levels, middle of each bar
    task automatic t_levels();
        for (int lv = 0; lv < 3; lv++) begin
            bar_en = 1'b1; ovl_en = 1'b0; level = 2'(lv);
            do_reset(1'b0);
            for (int i = 0; i < 8; i++) check_bar("R6", NTSC_E[i] + 44, lv);
        end
    endtask

    // R8 R6: overlay code sweep
    task automatic t_overlay();
        int y, cb, cr;
        bar_en = 1'b0; ovl_en = 1'b1; level = 2'd3;
        do_reset(1'b0);
        go(200);
        for (int lv = 3; lv >= 1; lv -= 2) begin
            for (int c = 0; c < 8; c++) begin
                {ovl_r, ovl_g, ovl_b} = 3'(c);
                level = 2'(lv);
                step();
                ref_col(c, lv, y, cb, cr);
                expect_out("R8 R6", $sformatf("overlay code %0d level %0d", c, lv), y, cb, cr, 1);
            end
        end
    endtask

    // R7 R8 R9: priority ladder
    task automatic t_priority();
        int y, cb, cr;
        bar_en = 1'b1; ovl_en = 1'b1; level = 2'd3;
        {ovl_r, ovl_g, ovl_b} = 3'b001;
        vid_y = 8'd77; vid_cb = 8'd33; vid_cr = 8'd200;
        do_reset(1'b0);
        go(300);
        ref_col(6, 3, y, cb, cr);
        expect_out("R7", "bar over overlay", y, cb, cr, 2);
        bar_en = 1'b0;
        step();
        ref_col(1, 3, y, cb, cr);
        expect_out("R8", "overlay over video", y, cb, cr, 1);
        ovl_en = 1'b0;
        step();
        expect_out("R9", "video when both off", 77, 33, 200, 0);
    endtask

    // R9 R10 R11: video pass-through, blanking, latency
    task automatic t_video();
        bar_en = 1'b0; ovl_en = 1'b0; level = 2'd0;
        vid_y = 8'd0; vid_cb = 8'd0; vid_cr = 8'd0;
        do_reset(1'b0);
        go(150);
        for (int k = 0; k < 4; k++) begin
            vid_y  = 8'(255 - 60 * k);
            vid_cb = 8'(3 + 70 * k);
            vid_cr = 8'(250 - 50 * k);
            step();
            expect_out("R9", "unscaled video", 255 - 60 * k, 3 + 70 * k, 250 - 50 * k, 0);
        end
        vid_y = 8'd200; vid_cb = 8'd10; vid_cr = 8'd20;
        step();
        expect_out("R11", "after edge", 200, 10, 20, 0);
        vid_y = 8'd50; vid_cb = 8'd60; vid_cr = 8'd70;
        #1;
        expect_out("R11", "input changed, no edge yet", 200, 10, 20, 0);
        step();
        expect_out("R11", "one edge later", 50, 60, 70, 0);
        go(50);
        expect_out("R10", "video in blanking", 16, 128, 128, 3);
        ovl_en = 1'b1; {ovl_r, ovl_g, ovl_b} = 3'b111;
        step();
        expect_out("R10", "overlay in blanking", 16, 128, 128, 3);
        bar_en = 1'b1;
        step();
        expect_out("R10", "bar in blanking", 16, 128, 128, 3);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_bars_ntsc();
        t_bars_pal();
        t_levels();
        t_overlay();
        t_priority();
        t_video();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule